// File: doc/BRIEF.md
# Streaming Bit-Reversal Reorder Buffer

This block sits in front of a decimation-in-time FFT pipeline. It takes complex samples in natural order, one per clock, and hands them on in bit-reversed order. For a frame of N points, output position j carries the input sample whose in-frame index is j with its log2(N) bits mirrored. For the default N = 512, that is the 9-bit write index reversed. The transform length N (a power of two, default 512) and the width of each real and imaginary part (default 12 bits) are parameters.

Two N-entry frame stores take turns. One fills at natural-order addresses while the other drains at mirrored addresses, and the two swap at every frame boundary. Because of this, an unbroken input stream leaves as an unbroken output stream after a latency of one frame. A start flag travelling with the first sample opens the stream. Valid samples offered before that flag are dropped. Each output sample comes with its position in the frame.

Both data sides use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. A source that sees in_ready low must hold its sample and keep in_valid high. in_ready falls only when both frame stores hold complete frames that are not yet drained. When the sink holds out_ready low, the current output sample and its index stay frozen. Once the sink stalls long enough, the stall reaches the input side through in_ready.

Top module: `bitrev_reorder`

## Requirements
- R1: A synchronous reset that is high on a rising edge leaves out_valid at 0, in_ready at 1 and out_index at 0 after the edge.
- R2: Before the stream has started, accepted-looking input (in_valid high with in_start low) is discarded. It produces no output, and it does not shift which sample becomes the first of frame 0.
- R3: The stream starts with the first transfer that has in_start high. That sample is sample 0 of frame 0. With in_valid and out_ready held high from then on, out_valid first goes high exactly N clock cycles after the cycle of that transfer.
- R4: Output position j of frame f carries input sample f*N + rev(j), where rev mirrors the log2(N)-bit value of j (bit 0 swaps with bit log2(N)-1, and so on). The real part appears on out_re and the imaginary part on out_im.
- R5: out_index equals j for each output sample. It counts 0 to N-1 over the transfers of a frame and returns to 0 after N-1.
- R6: With in_valid and out_ready held high, in_ready stays high throughout, and out_valid stays high on every cycle once it has risen.
- R7: While out_valid is high and out_ready is low, the next cycle keeps out_valid high and out_re, out_im and out_index unchanged.
- R8: in_ready is low exactly when both frame stores hold complete, undrained frames. With the sink stalled and input offered every cycle, exactly 2N samples are taken, and no sample is lost or taken twice.
- R9: A high in_start on any transfer after the stream has started has no effect on ordering.
- R10: Idle cycles on either side (in_valid low, out_ready low) only delay the stream. The order of R4 and the index of R5 still hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take an input sample |
| in_start | input | 1 | Marks the first sample of the stream |
| in_re | input | SW | Real part of input sample |
| in_im | input | SW | Imaginary part of input sample |
| out_valid | output | 1 | Output sample available |
| out_ready | input | 1 | Sink takes the output sample |
| out_re | output | SW | Real part of reordered sample |
| out_im | output | SW | Imaginary part of reordered sample |
| out_index | output | log2(N) | Position of the output sample within its frame |

## Verification
The hardest situation to reach is the one where both frame stores are full, the sink is stalled, and the source keeps offering samples. Only then does in_ready drop, and only then can a missed hold cause a lost or doubled sample. The stimulus holds out_ready low for three frame lengths while offering input every cycle. It confirms that exactly 2N samples were taken and that the outputs stay frozen during the stall. It then releases the sink and checks that the rest of the stream comes out in mirrored order with no gap. Further runs mix idle cycles on both sides and repeat the start flag in the middle of the stream.

// File: rtl/bitrev_pkg.sv
package bitrev_pkg;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_sel_e;

  function automatic bank_sel_e other_bank(bank_sel_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction

endpackage

// File: rtl/bitrev_bank.sv
module bitrev_bank #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned DW    = 24,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/bitrev_wr_ctrl.sv
module bitrev_wr_ctrl
  import bitrev_pkg::*;
#(
  parameter int unsigned N  = 512,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_start,
  input  logic [1:0]    bank_full,
  output logic          in_ready,
  output logic [1:0]    bank_we,
  output logic [AW-1:0] waddr,
  output logic [1:0]    fill_done,
  output logic          streaming
);

  localparam logic [AW-1:0] LAST = AW'(N - 1);

  bank_sel_e     wsel;
  logic [AW-1:0] wcnt;
  logic          take;

  assign in_ready = (wsel == BANK_A) ? !bank_full[0] : !bank_full[1];
  assign take     = in_ready && in_valid && (streaming || in_start);
  assign waddr    = wcnt;

  always_comb begin
    bank_we   = '0;
    fill_done = '0;
    if (take) begin
      bank_we[wsel] = 1'b1;
      if (wcnt == LAST) fill_done[wsel] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      streaming <= 1'b0;
      wsel      <= BANK_A;
      wcnt      <= '0;
    end else if (take) begin
      streaming <= 1'b1;
      if (wcnt == LAST) begin
        wcnt <= '0;
        wsel <= other_bank(wsel);
      end else begin
        wcnt <= wcnt + AW'(1);
      end
    end
  end

  // R3: once opened, the stream stays open until reset
  a_r3_stream_sticky: assert property (@(posedge clk) disable iff (rst)
    streaming |=> streaming);

  // R10: write address only moves on a taken sample
  a_r10_addr_holds: assert property (@(posedge clk) disable iff (rst)
    !(|bank_we) |=> $stable(waddr));

endmodule

// File: rtl/bitrev_rd_ctrl.sv
module bitrev_rd_ctrl
  import bitrev_pkg::*;
#(
  parameter int unsigned N  = 512,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bank_full,
  input  logic          out_ready,
  output logic          out_valid,
  output bank_sel_e     rsel,
  output logic [AW-1:0] raddr,
  output logic [AW-1:0] out_index,
  output logic [1:0]    drain_done
);

  localparam logic [AW-1:0] LAST = AW'(N - 1);

  logic [AW-1:0] rcnt;
  logic          fire;

  assign out_valid = (rsel == BANK_A) ? bank_full[0] : bank_full[1];
  assign fire      = out_valid && out_ready;
  assign out_index = rcnt;

  always_comb begin
    for (int i = 0; i < AW; i++) raddr[i] = rcnt[AW-1-i];
  end

  always_comb begin
    drain_done = '0;
    if (fire && rcnt == LAST) drain_done[rsel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rcnt <= '0;
      rsel <= BANK_A;
    end else if (fire) begin
      if (rcnt == LAST) begin
        rcnt <= '0;
        rsel <= other_bank(rsel);
      end else begin
        rcnt <= rcnt + AW'(1);
      end
    end
  end

  // R5: index steps by one inside a frame
  a_r5_index_step: assert property (@(posedge clk) disable iff (rst)
    (fire && out_index != LAST) |=> out_index == $past(out_index) + AW'(1));

  // R5: index wraps and the other store takes over
  a_r5_index_wrap: assert property (@(posedge clk) disable iff (rst)
    (fire && out_index == LAST) |=> (out_index == '0) && (rsel != $past(rsel)));

endmodule

// File: rtl/bitrev_reorder.sv
module bitrev_reorder
  import bitrev_pkg::*;
#(
  parameter int unsigned N  = 512,
  parameter int unsigned SW = 12,
  localparam int unsigned AW = $clog2(N),
  localparam int unsigned DW = 2 * SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_start,
  input  logic [SW-1:0] in_re,
  input  logic [SW-1:0] in_im,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_re,
  output logic [SW-1:0] out_im,
  output logic [AW-1:0] out_index
);

  logic [1:0]    bank_full;
  logic [1:0]    bank_we;
  logic [1:0]    fill_done;
  logic [1:0]    drain_done;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic          streaming;
  bank_sel_e     rd_sel;
  logic [DW-1:0] rd_word [2];
  logic [DW-1:0] out_word;

  bitrev_wr_ctrl #(.N(N)) i_wr (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_start  (in_start),
    .bank_full (bank_full),
    .in_ready  (in_ready),
    .bank_we   (bank_we),
    .waddr     (waddr),
    .fill_done (fill_done),
    .streaming (streaming)
  );

  bitrev_rd_ctrl #(.N(N)) i_rd (
    .clk        (clk),
    .rst        (rst),
    .bank_full  (bank_full),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .rsel       (rd_sel),
    .raddr      (raddr),
    .out_index  (out_index),
    .drain_done (drain_done)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                bank_full[b] <= 1'b0;
      else if (fill_done[b])  bank_full[b] <= 1'b1;
      else if (drain_done[b]) bank_full[b] <= 1'b0;
    end

    bitrev_bank #(.DEPTH(N), .DW(DW)) i_bank (
      .clk   (clk),
      .we    (bank_we[b]),
      .waddr (waddr),
      .wdata ({in_re, in_im}),
      .raddr (raddr),
      .rdata (rd_word[b])
    );
  end

  assign out_word = (rd_sel == BANK_B) ? rd_word[1] : rd_word[0];
  assign out_re   = out_word[DW-1:SW];
  assign out_im   = out_word[SW-1:0];

  // R1: leaving reset, nothing is offered and the index is cleared
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && out_index == '0 && in_ready));

  // R2: no output before the stream has been opened
  a_r2_no_early_output: assert property (@(posedge clk) disable iff (rst)
    !streaming |-> !out_valid);

  // R7: a stalled output sample is held unchanged
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_index) && $stable(out_re) && $stable(out_im)));

  // R8: the store being drained is never written
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !bank_we[rd_sel]);

endmodule

// File: tb/test_bitrev_reorder.sv
module test_bitrev_reorder;

  localparam int N  = 16;
  localparam int SW = 12;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_start = 1'b0;
  logic [SW-1:0] in_re = '0;
  logic [SW-1:0] in_im = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [SW-1:0] out_re;
  logic [SW-1:0] out_im;
  logic [AW-1:0] out_index;

  int vec = 0;
  int bad = 0;
  int src_k = 0;
  int exp_m = 0;
  bit opened = 0;
  bit was_stalled = 0;
  logic [SW-1:0] held_re, held_im;
  logic [AW-1:0] held_idx;
  int wd = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bitrev_reorder #(.N(N), .SW(SW)) i_bitrev_reorder (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_start(in_start),
    .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .out_index(out_index)
  );

  function automatic logic [SW-1:0] re_of(int k);
    return SW'(k * 37 + 5);
  endfunction

  function automatic logic [SW-1:0] im_of(int k);
    return SW'(4095 - k * 11);
  endfunction

  function automatic int rev(int j);
    int r = 0;
    for (int i = 0; i < AW; i++) if (j[i]) r |= 1 << (AW - 1 - i);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // one clock: drive inputs, sample outputs, model transfers, check output sample
  task automatic step(input logic v, input logic st, input logic rdy);
    int k, j;
    @(negedge clk);
    in_valid  = v;
    in_start  = st;
    in_re     = (opened || st) ? re_of(src_k) : 12'hABC;
    in_im     = (opened || st) ? im_of(src_k) : 12'h5A5;
    out_ready = rdy;
    #1;
    if (was_stalled) begin
      // R7
      check(out_valid == 1'b1, "R7 valid held", int'(out_valid), 1);
      check(out_re == held_re && out_im == held_im && out_index == held_idx,
            "R7 data held", int'(out_re), int'(held_re));
    end
    if (out_valid) begin
      if (rdy) begin
        j = exp_m % N;
        k = (exp_m / N) * N + rev(j);
        check(out_re == re_of(k), "R4 real part", int'(out_re), int'(re_of(k)));
        check(out_im == im_of(k), "R4 imag part", int'(out_im), int'(im_of(k)));
        check(int'(out_index) == j, "R5 index", int'(out_index), j);
        exp_m++;
      end
    end
    was_stalled = out_valid && !rdy;
    held_re = out_re; held_im = out_im; held_idx = out_index;
    if (v && in_ready && (opened || st)) begin
      opened = 1;
      src_k++;
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 0; in_start = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    src_k = 0; exp_m = 0; opened = 0; was_stalled = 0;
  endtask

  task automatic t_reset();
    apply_reset();
    #1;
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(out_index == '0, "R1 out_index", int'(out_index), 0);
  endtask

  task automatic t_idle_ignored();
    bit any = 0;
    apply_reset();
    for (int c = 0; c < 3 * N; c++) begin
      step(1'b1, 1'b0, 1'b1);
      if (out_valid) any = 1;
    end
    check(any == 0, "R2 no output before start", int'(any), 0);
    check(src_k == 0, "R2 nothing taken before start", src_k, 0);
    for (int c = 0; c < 3 * N; c++) step(1'b1, c == 0, 1'b1);
    check(exp_m == 2 * N, "R2 outputs after start", exp_m, 2 * N);
  endtask

  task automatic t_continuous();
    int first = -1;
    apply_reset();
    for (int c = 0; c < 5 * N; c++) begin
      // R9: start flag repeated mid-stream
      step(1'b1, (c == 0 || c == 5 || c == N + 3), 1'b1);
      check(in_ready == 1'b1, "R6 in_ready stays high", int'(in_ready), 1);
      if (out_valid && first < 0) first = c;
      if (first >= 0)
        check(out_valid == 1'b1, "R6 out_valid stays high", int'(out_valid), 1);
    end
    check(first == N, "R3 first output latency", first, N);
    check(exp_m == 4 * N, "R9 output count", exp_m, 4 * N);
  endtask

  task automatic t_backpressure();
    apply_reset();
    for (int c = 0; c < 3 * N; c++) step(1'b1, c == 0, 1'b0);
    check(src_k == 2 * N, "R8 samples taken while stalled", src_k, 2 * N);
    check(in_ready == 1'b0, "R8 in_ready low when full", int'(in_ready), 0);
    check(out_valid == 1'b1, "R7 valid during stall", int'(out_valid), 1);
    for (int c = 0; c < 3 * N; c++) step(1'b1, 1'b0, (c % 3) != 0);
    for (int c = 0; c < 2 * N; c++) step(1'b0, 1'b0, 1'b1);
    check(exp_m == src_k - (src_k % N), "R8 no sample lost", exp_m, src_k - (src_k % N));
  endtask

  task automatic t_gaps();
    apply_reset();
    for (int c = 0; c < 6 * N; c++) step((c % 5) != 2, c == 0, (c % 4) != 1);
    for (int c = 0; c < 2 * N; c++) step(1'b0, 1'b0, 1'b1);
    check(exp_m == src_k - (src_k % N), "R10 frames drained", exp_m, src_k - (src_k % N));
    check(exp_m >= 3 * N, "R10 progress", exp_m, 3 * N);
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000 && !done) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_ignored();
    t_continuous();
    t_backpressure();
    t_gaps();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule